// File: doc/BRIEF.md
# Key-Gated Register Window

This block sits on a simple single-cycle register bus and guards a small bank of protected registers behind two magic-value writes. The first is a one-time initiation key. It takes the block out of its power-on reset state for good. The second is a renewable access key. It opens a read/write window that closes by itself after a fixed number of slow-clock ticks.

While the block is active and the window is open, bus writes to the protected bank are stored, and a one-hot gated write-enable is driven toward downstream logic. Reads of the bank return the stored values. At any other time, writes to the bank are dropped and reads of it return zero.

The design runs on one clock. A slow-tick enable input marks the cycles that count toward the window's lifetime. Crossing between clock domains is left to the surrounding logic.

Top module: `keyguard`

## Requirements
- R1: After reset, `active_o` and `window_o` are 0, `gated_we_o` is 0, and every bus read returns 0.
- R2: A bus write of exactly 0xA5EB1357 to offset 0x00 sets `active_o` to 1. It then stays 1 until the next reset, whatever is written afterwards.
- R3: A read of offset 0x00 returns the active status in bit 0 and zeros in bits 31:1. The written key is never read back.
- R4: A write to offset 0x04 whose bits 15:0 equal 0xA965 opens the window (`window_o` = 1), whatever the bits 31:16 hold. A read of offset 0x04 returns the window flag in bit 16 and zeros elsewhere.
- R5: The window closes on the 1024th clock edge at which `slow_tick` is high, counted after the key write. Edges with `slow_tick` low do not count.
- R6: Writing the access key again while the window is open restarts the 1024-tick count from zero.
- R7: A write of any other value to offset 0x00 or 0x04 has no effect. It does not open, close or restart the window, and it does not change the active status.
- R8: The protected bank holds 4 words at offsets 0x10, 0x14, 0x18 and 0x1C. A write is stored only when the block is active and the window is open. Otherwise reads of the bank return 0. Stored contents are kept across closed windows.
- R9: `gated_we_o[i]` is 1 only in a cycle where `bus_we` is high, the address is bank word i, the block is active and the window is open. At most one bit of `gated_we_o` is set.
- R10: Reads of addresses that are not mapped return 0, and this includes offsets that are not word-aligned. Writes to such addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| slow_tick | input | 1 | Slow-clock enable; counts toward window expiry |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, single cycle |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| active_o | output | 1 | Initiation key accepted |
| window_o | output | 1 | Access window open |
| gated_we_o | output | 4 | One-hot write-enable for protected words |

## Verification
The key registers are written with the exact keys, with keys that are one bit off, with all-zero and all-one words, and with the access key carrying junk in its upper half. This separates full-word matching from partial matching and from matching only the low half.

The bank is written in the following states:
- inactive with the window closed;
- inactive with the window open;
- active with the window open;
- active after the window has expired.

These show that the gate needs both conditions. They also show that the stored contents survive a closed window.

Window expiry is driven with a run of ticks that stops one short of the limit, then with idle cycles in which no tick arrives, and then with a second key written part way through a window. This separates counting ticks from counting clocks, and it separates restarting the count from merely keeping the window open.

// File: rtl/keyguard.sv
module keyguard #(
  parameter int          ADDR_W       = 8,
  parameter int          DATA_W       = 32,
  parameter int          NUM_REGS     = 4,
  parameter int          WINDOW_TICKS = 1024,
  parameter logic [31:0] INIT_KEY     = 32'hA5EB1357,
  parameter logic [15:0] ACC_KEY      = 16'hA965,
  parameter int          INIT_OFS     = 'h00,
  parameter int          ACC_OFS      = 'h04,
  parameter int          BANK_OFS     = 'h10,
  parameter int          FLAG_BIT     = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                slow_tick,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic                bus_we,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                active_o,
  output logic                window_o,
  output logic [NUM_REGS-1:0] gated_we_o
);
  localparam int CNT_W = $clog2(WINDOW_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WINDOW_TICKS - 1);

  logic              active_q, window_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] bank_q [NUM_REGS];
  logic [NUM_REGS-1:0] hit;

  wire init_hit = bus_addr == ADDR_W'(INIT_OFS);
  wire acc_hit  = bus_addr == ADDR_W'(ACC_OFS);
  wire init_ok  = bus_we && init_hit && (bus_wdata[31:0] == INIT_KEY);
  wire acc_ok   = bus_we && acc_hit && (bus_wdata[15:0] == ACC_KEY);
  wire open_w   = active_q && window_q;

  assign active_o   = active_q;
  assign window_o   = window_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       active_q <= 1'b0;
    else if (init_ok) active_q <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      window_q <= 1'b0;
      cnt_q    <= '0;
    end else if (acc_ok) begin
      window_q <= 1'b1;
      cnt_q    <= '0;
    end else if (window_q && slow_tick) begin
      if (cnt_q == CNT_LAST) begin
        window_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_bank
    assign hit[i]        = bus_addr == ADDR_W'(BANK_OFS + 4 * i);
    assign gated_we_o[i] = bus_we && hit[i] && open_w;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)             bank_q[i] <= '0;
      else if (gated_we_o[i]) bank_q[i] <= bus_wdata;
  end

  always_comb begin
    bus_rdata = '0;
    if (init_hit) bus_rdata[0] = active_q;
    if (acc_hit)  bus_rdata[FLAG_BIT] = window_q;
    for (int i = 0; i < NUM_REGS; i++)
      if (hit[i] && open_w) bus_rdata = bank_q[i];
  end
endmodule

module keyguard_chk #(
  parameter int ADDR_W = 8, parameter int DATA_W = 32, parameter int NUM_REGS = 4,
  parameter int ACC_OFS = 'h04, parameter int INIT_OFS = 'h00
) (
  input logic clk, rst_n, slow_tick, bus_we, active_o, window_o,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata, bus_rdata,
  input logic [NUM_REGS-1:0] gated_we_o
);
  p_active_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    active_o |=> active_o);
  p_init_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(INIT_OFS)) |-> (bus_rdata[DATA_W-1:1] == '0));
  p_window_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(window_o) |-> $past(bus_we && bus_addr == ADDR_W'(ACC_OFS) && bus_wdata[15:0] == 16'hA965));
  p_close_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(window_o) |-> $past(slow_tick));
  p_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|gated_we_o) |-> (active_o && window_o && bus_we));
  p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gated_we_o));
endmodule

bind keyguard keyguard_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS),
  .ACC_OFS(ACC_OFS), .INIT_OFS(INIT_OFS)) u_chk (
  .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .bus_we(bus_we),
  .active_o(active_o), .window_o(window_o), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gated_we_o(gated_we_o));

// File: tb/sim_keyguard.sv
module sim_keyguard;
  logic clk = 0, rst_n = 0, slow_tick = 0, bus_we = 0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic active_o, window_o;
  logic [3:0] gated_we_o;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  keyguard u0 (.clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata),
    .active_o(active_o), .window_o(window_o), .gated_we_o(gated_we_o));

  typedef struct packed {
    logic [7:0] waddr; logic [31:0] wdata; logic [7:0] raddr; logic [31:0] exp; logic [3:0] req;
  } vec_t;

  localparam vec_t VECS [14] = '{
    '{8'h10, 32'h11111111, 8'h10, 32'h0,        4'd8},  // R8 inactive, closed
    '{8'h00, 32'h12345678, 8'h00, 32'h0,        4'd7},  // R7 wrong init key
    '{8'h04, 32'h0000A965, 8'h04, 32'h00010000, 4'd4},  // R4 window opens
    '{8'h10, 32'h22222222, 8'h10, 32'h0,        4'd8},  // R8 open but inactive
    '{8'h00, 32'hA5EB1357, 8'h00, 32'h1,        4'd2},  // R2 init key
    '{8'h10, 32'h33333333, 8'h10, 32'h33333333, 4'd8},  // R8 stored
    '{8'h1C, 32'h44444444, 8'h1C, 32'h44444444, 4'd8},  // R8 last word
    '{8'h04, 32'h0000A964, 8'h04, 32'h00010000, 4'd7},  // R7 bad access key keeps window
    '{8'h00, 32'h00000000, 8'h00, 32'h1,        4'd2},  // R2 sticky
    '{8'h00, 32'hFFFFFFFF, 8'h00, 32'h1,        4'd3},  // R3 key not read back
    '{8'h20, 32'h55555555, 8'h20, 32'h0,        4'd10}, // R10 unmapped
    '{8'h12, 32'h77777777, 8'h10, 32'h33333333, 4'd10}, // R10 misaligned write
    '{8'h04, 32'hFFFFA965, 8'h04, 32'h00010000, 4'd4},  // R4 upper half ignored
    '{8'h14, 32'h66666666, 8'h14, 32'h66666666, 4'd8}   // R8 second word
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); slow_tick = 1;
    repeat (n) @(negedge clk);
    slow_tick = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 active", {31'b0, active_o}, 0);
    chk("R1 window", {31'b0, window_o}, 0);
    rd(8'h10, r); chk("R1 bank read", r, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 gated_we", {28'b0, gated_we_o}, 0);

    foreach (VECS[i]) begin
      wr(VECS[i].waddr, VECS[i].wdata);
      rd(VECS[i].raddr, r);
      chk($sformatf("R%0d vec%0d", VECS[i].req, i), r, VECS[i].exp);
    end

    // R9 gated write-enable in the write cycle
    @(negedge clk); bus_we = 1; bus_addr = 8'h18; bus_wdata = 32'h88888888;
    #1 chk("R9 gated_we one-hot", {28'b0, gated_we_o}, 32'h4);
    @(negedge clk); bus_we = 0;
    #1 chk("R9 gated_we idle", {28'b0, gated_we_o}, 0);

    // R5 expiry counts ticks only
    wr(8'h04, 32'h0000A965);
    ticks(1023);
    chk("R5 open after 1023 ticks", {31'b0, window_o}, 1);
    repeat (50) @(negedge clk);
    chk("R5 no tick no count", {31'b0, window_o}, 1);
    ticks(1);
    chk("R5 closed at 1024", {31'b0, window_o}, 0);
    rd(8'h04, r); chk("R5 flag read", r, 0);
    rd(8'h10, r); chk("R8 closed read zero", r, 0);
    @(negedge clk); bus_we = 1; bus_addr = 8'h10; bus_wdata = 32'h99999999;
    #1 chk("R9 closed no gated_we", {28'b0, gated_we_o}, 0);
    @(negedge clk); bus_we = 0;
    wr(8'h04, 32'h0000A964);
    chk("R7 bad key no open", {31'b0, window_o}, 0);

    // R6 restart
    wr(8'h04, 32'h0000A965);
    ticks(600);
    wr(8'h04, 32'h0000A965);
    ticks(1023);
    chk("R6 open after restart", {31'b0, window_o}, 1);
    rd(8'h10, r); chk("R8 contents kept", r, 32'h33333333);
    ticks(1);
    chk("R6 closed after restart", {31'b0, window_o}, 0);

    // R1 R2 a new reset clears the active status
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    chk("R2 cleared by reset", {31'b0, active_o}, 0);
    rst_n = 1;
    rd(8'h00, r); chk("R1 init read after reset", r, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule